// File: doc/BRIEF.md
# Watchdog Timer with Status-Lights Register

This peripheral sits on a simple programmed-I/O bus. Each command presents an instruction kind, a function code and a 16-bit data word. Two commands are legal. A control pulse with function 0 restarts the watchdog. An output transfer with function 0 writes a status-lights register, which drives a bank of indicator outputs. Every other combination of kind and function is refused as unimplemented.

Once restarted, the watchdog loads its countdown from a configured delay measured in millisecond ticks. Each tick strobe decrements the countdown. When the countdown runs out, a sticky timed-out flag raises a non-maskable trap request. A fixed trap vector, 062 octal by default, goes out with the request. A configured delay of zero disables the watchdog.

The command port is a one-way stream with a valid strobe and no ready signal. The block accepts one command on every cycle in which `io_valid` is high, so it never applies back-pressure. Exactly one response pulse, `io_done` or `io_bad`, follows each command one cycle later. The tick strobe, the delay setting and the trap pins are plain level or strobe signals.

Top module: `sentinel_watchdog`

## Requirements
- R1: While `rst_n` is low, and until the first command after it, `lights` is 0, `trap_req` is low and neither `io_done` nor `io_bad` is high. Reset also empties the countdown.
- R2: A command with `io_kind`=0 (control pulse) and `io_func`=0 restarts the watchdog. The countdown is reloaded from `cfg_delay` and `trap_req` is cleared. `io_done` pulses in the following cycle.
- R3: After a restart with delay D>0, `trap_req` stays low through D-1 tick edges. It goes high right after the clock edge on which the D-th tick is sampled.
- R4: Once high, `trap_req` stays high across further ticks and across other commands, until a restart, a reset or a zero delay.
- R5: While `cfg_delay` is 0, ticks have no effect, and `trap_req` is low from the cycle after the zero is seen.
- R6: A command with `io_kind`=3 (output transfer) and `io_func`=0 loads `io_wdata` into `lights`, visible in the next cycle together with `io_done`. `lights` holds between writes. Rewriting the same value changes nothing, including the watchdog.
- R7: Any other kind/function pair (`io_kind` 1 or 2, or a nonzero `io_func`) produces an `io_bad` pulse in the next cycle. It leaves `lights` and the countdown unchanged.
- R8: `trap_vector` always carries the fixed trap location, 062 octal.
- R9: When a restart and a tick arrive in the same cycle, the restart wins and the countdown holds the full delay.
- R10: After reset, ticks do not raise a trap until the first restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Command strobe, one command per high cycle |
| io_kind | input | 2 | Instruction kind: 0 control, 1 sense, 2 input, 3 output |
| io_func | input | 4 | Function code |
| io_wdata | input | 16 | Data word of an output transfer |
| io_done | output | 1 | Command accepted, one cycle after it |
| io_bad | output | 1 | Command refused as unimplemented, one cycle after it |
| ms_tick | input | 1 | Millisecond tick strobe |
| cfg_delay | input | 16 | Timeout in ticks, 0 disables the watchdog |
| lights | output | 16 | Status-lights register |
| trap_req | output | 1 | Non-maskable trap request (level) |
| trap_vector | output | 9 | Fixed trap location |

## Verification
Some properties are checked on every cycle:
- The trap flag is sticky.
- A restart clears the flag, and a zero delay forces it low.
- The flag only rises on a tick.
- The lights hold when no load occurs.
- A refused command always returns `io_bad`, never together with `io_done`.

Other behaviour needs the bench's scenarios:
- The exact number of ticks before the trap rises.
- A restart winning over a simultaneous tick.
- A refused control pulse leaving a running countdown untouched.
- The full reset state after a trap.

// File: rtl/sentinel_wdt_pkg.sv
package sentinel_wdt_pkg;
  localparam int KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    KIND_CTRL  = 2'd0,
    KIND_SENSE = 2'd1,
    KIND_IN    = 2'd2,
    KIND_OUT   = 2'd3
  } io_kind_e;

  typedef struct packed {
    logic restart;
    logic load_lights;
    logic refuse;
  } io_action_t;
endpackage

// File: rtl/sentinel_cmd_decode.sv
module sentinel_cmd_decode
  import sentinel_wdt_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic [KIND_W-1:0] io_kind,
  input  logic [FUNC_W-1:0] io_func,
  output io_action_t        act,
  output logic              io_done,
  output logic              io_bad
);
  io_kind_e kind;
  logic     fn_zero;

  always_comb begin
    kind            = io_kind_e'(io_kind);
    fn_zero         = (io_func == '0);
    act.restart     = io_valid && fn_zero && (kind == KIND_CTRL);
    act.load_lights = io_valid && fn_zero && (kind == KIND_OUT);
    act.refuse      = io_valid && !act.restart && !act.load_lights;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_done <= 1'b0;
      io_bad  <= 1'b0;
    end else begin
      io_done <= act.restart || act.load_lights;
      io_bad  <= act.refuse;
    end
  end

  assert_refuse_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && (io_func != '0)) |=> io_bad);
  assert_reply_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_done && io_bad));
endmodule

// File: rtl/sentinel_countdown.sv
module sentinel_countdown #(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic [DELAY_W-1:0] delay,
  output logic               timed_out
);
  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] remain;
  logic               disabled;

  assign disabled = (delay == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      timed_out <= 1'b0;
    end else if (restart) begin
      remain    <= delay;
      timed_out <= 1'b0;
    end else if (disabled) begin
      timed_out <= 1'b0;
    end else if (tick && (remain != '0)) begin
      remain <= remain - ONE;
      if (remain == ONE) timed_out <= 1'b1;
    end
  end

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !timed_out);
  assert_trap_rises_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> $past(tick));
  assert_trap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !restart && !disabled) |=> timed_out);
  assert_zero_delay_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !timed_out);
endmodule

// File: rtl/sentinel_lights_reg.sv
module sentinel_lights_reg #(
  parameter int LIGHT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LIGHT_W-1:0] wdata,
  output logic [LIGHT_W-1:0] lights
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lights <= '0;
    else if (load) lights <= wdata;
  end

  assert_lights_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lights));
endmodule

// File: rtl/sentinel_watchdog.sv
module sentinel_watchdog
  import sentinel_wdt_pkg::*;
#(
  parameter int FUNC_W   = 4,
  parameter int DATA_W   = 16,
  parameter int DELAY_W  = 16,
  parameter int VEC_W    = 9,
  parameter int TRAP_LOC = 'o62
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_valid,
  input  logic [KIND_W-1:0]  io_kind,
  input  logic [FUNC_W-1:0]  io_func,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic               io_done,
  output logic               io_bad,
  input  logic               ms_tick,
  input  logic [DELAY_W-1:0] cfg_delay,
  output logic [DATA_W-1:0]  lights,
  output logic               trap_req,
  output logic [VEC_W-1:0]   trap_vector
);
  io_action_t act;

  sentinel_cmd_decode #(.FUNC_W(FUNC_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_kind(io_kind),
    .io_func(io_func), .act(act), .io_done(io_done), .io_bad(io_bad)
  );

  sentinel_countdown #(.DELAY_W(DELAY_W)) u_count (
    .clk(clk), .rst_n(rst_n), .restart(act.restart), .tick(ms_tick),
    .delay(cfg_delay), .timed_out(trap_req)
  );

  sentinel_lights_reg #(.LIGHT_W(DATA_W)) u_lights (
    .clk(clk), .rst_n(rst_n), .load(act.load_lights), .wdata(io_wdata),
    .lights(lights)
  );

  assign trap_vector = VEC_W'(TRAP_LOC);

  assert_refuse_keeps_lights_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act.refuse |=> $stable(lights));
endmodule

// File: tb/sentinel_watchdog_test.sv
module sentinel_watchdog_test;
  typedef struct { bit bad; logic [15:0] lt; string req; } exp_t;

  logic clk = 0, rst_n = 0, io_valid = 0, ms_tick = 0;
  logic [1:0] io_kind = 0;
  logic [3:0] io_func = 0;
  logic [15:0] io_wdata = 0, cfg_delay = 16'd5;
  logic io_done, io_bad, trap_req;
  logic [15:0] lights;
  logic [8:0] trap_vector;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] exp_lights = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  sentinel_watchdog uut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_kind(io_kind),
    .io_func(io_func), .io_wdata(io_wdata), .io_done(io_done), .io_bad(io_bad),
    .ms_tick(ms_tick), .cfg_delay(cfg_delay), .lights(lights),
    .trap_req(trap_req), .trap_vector(trap_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: issue one command (optionally with a tick) and queue its expected reply.
  task automatic io_cmd(input logic [1:0] k, input logic [3:0] f, input logic [15:0] d,
                        input bit with_tick, input string req);
    exp_t e;
    bit legal;
    legal = (f == 0) && (k == 2'd0 || k == 2'd3);
    if (legal && k == 2'd3) exp_lights = d;
    e.bad = !legal; e.lt = exp_lights; e.req = req;
    @(negedge clk);
    io_valid = 1; io_kind = k; io_func = f; io_wdata = d; ms_tick = with_tick;
    q.push_back(e);
    @(negedge clk);
    io_valid = 0; ms_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1;
      @(negedge clk); ms_tick = 0;
    end
  endtask

  // Monitor: pop the expected reply whenever the design answers.
  always @(negedge clk) begin
    if (rst_n && (io_done || io_bad)) begin
      if (q.size() == 0) begin
        check("unexpected reply", {31'd0, io_bad}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " reply"}, {30'd0, io_done, io_bad}, {30'd0, !e.bad, e.bad});
        check({e.req, " lights"}, {16'd0, lights}, {16'd0, e.lt});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lights", {16'd0, lights}, 0);
    check("R1 trap", {31'd0, trap_req}, 0);
    check("R1 reply", {30'd0, io_done, io_bad}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 reply after reset", {30'd0, io_done, io_bad}, 0);
    check("R8 vector", {23'd0, trap_vector}, 32'o62);

    ticks(10);
    check("R10 idle after reset", {31'd0, trap_req}, 0);

    io_cmd(0, 0, 0, 0, "R2 restart");
    ticks(4);
    check("R3 before expiry", {31'd0, trap_req}, 0);
    ticks(1);
    check("R3 at expiry", {31'd0, trap_req}, 1);
    ticks(3);
    check("R4 sticky across ticks", {31'd0, trap_req}, 1);
    io_cmd(3, 0, 16'hA5A5, 0, "R6 write");
    check("R4 sticky across write", {31'd0, trap_req}, 1);
    io_cmd(0, 0, 0, 0, "R2 restart");
    check("R2 restart clears trap", {31'd0, trap_req}, 0);

    io_cmd(3, 0, 16'hA5A5, 0, "R6 same value");
    ticks(4);
    check("R6 same value no side effect", {31'd0, trap_req}, 0);
    check("R6 lights hold", {16'd0, lights}, 32'hA5A5);

    io_cmd(0, 0, 0, 0, "R2 restart");
    ticks(3);
    io_cmd(3, 1, 16'h1234, 0, "R7 out fn1");
    io_cmd(1, 0, 16'h5678, 0, "R7 sense");
    io_cmd(2, 0, 16'h9ABC, 0, "R7 input");
    io_cmd(0, 5, 0, 0, "R7 ctrl fn5");
    check("R7 lights unchanged", {16'd0, lights}, 32'hA5A5);
    ticks(1);
    check("R7 countdown kept", {31'd0, trap_req}, 0);
    ticks(1);
    check("R7 countdown not restarted", {31'd0, trap_req}, 1);

    io_cmd(0, 0, 0, 0, "R9 restart");
    ticks(4);
    io_cmd(0, 0, 0, 1, "R9 restart with tick");
    ticks(4);
    check("R9 restart beats tick", {31'd0, trap_req}, 0);
    ticks(1);
    check("R9 full delay", {31'd0, trap_req}, 1);

    cfg_delay = 0;
    @(negedge clk);
    check("R5 zero delay drops trap", {31'd0, trap_req}, 0);
    io_cmd(0, 0, 0, 0, "R5 restart");
    ticks(20);
    check("R5 never traps", {31'd0, trap_req}, 0);

    cfg_delay = 16'd2;
    io_cmd(0, 0, 0, 0, "R2 restart");
    ticks(2);
    check("R3 short delay", {31'd0, trap_req}, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 reset lights", {16'd0, lights}, 0);
    check("R1 reset trap", {31'd0, trap_req}, 0);
    rst_n = 1; exp_lights = 0;
    ticks(5);
    check("R10 no trap after reset", {31'd0, trap_req}, 0);
    check("scoreboard drained", q.size(), 0);
    finish_up();
  end
endmodule